// File: doc/BRIEF.md
# Byte and Halfword Lane Select Unit

This unit takes a 32-bit word and returns one of its narrower pieces, either a single byte or a 16-bit halfword, widened back to a full word. It lets software on a machine that can only move whole aligned words pick out sub-word data. A typical use is to finish an unaligned load, or to handle 8-bit and 16-bit variables. The piece is chosen by a byte offset. The offset comes either from the low bits of a second register, for example the address the word was fetched from, or from a small immediate field in the instruction.

The result is widened by one of two rules. With a register-supplied offset it is always zero-extended. With an immediate offset the caller picks zero or sign extension. The selection logic is combinational and feeds a single result register, so a result appears one clock after its operands. Memory access and instruction decoding are not part of the block.

Top module: `byte_half_select`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, `result` is all zeros after that edge.
- R2: `result` changes only at a rising edge and then reflects the inputs sampled at that edge. Input changes between edges do not reach `result` until the next edge.
- R3: With `size_half`=0 (byte), offset 0 selects bits 7:0, offset 1 selects bits 15:8, offset 2 selects bits 23:16 and offset 3 selects bits 31:24. The selected byte lands in `result[7:0]`.
- R4: With `size_half`=1 (halfword), offset bit 1 chooses the halfword: 0 selects bits 15:0 and 1 selects bits 31:16. Offset bit 0 has no effect. The selected halfword lands in `result[15:0]`.
- R5: With `use_imm`=0, the offset is `sel_reg[1:0]`. Bits 31:2 of `sel_reg` and the whole of `sel_imm` have no effect.
- R6: With `use_imm`=1, the offset is `sel_imm[1:0]`. The upper bits of `sel_imm` and the whole of `sel_reg` have no effect.
- R7: With `use_imm`=0, the upper bits of `result` above the selected lane are always zero, whatever the value of `signed_en`.
- R8: With `use_imm`=1, `signed_en`=1 copies the top bit of the selected lane into every upper bit of `result`, and `signed_en`=0 zero-fills them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_word | input | WORD_W (32) | Word to select a lane from |
| sel_reg | input | WORD_W (32) | Register operand whose low bits give the byte offset when `use_imm`=0 |
| sel_imm | input | IMM_W (4) | Immediate field whose low bits give the byte offset when `use_imm`=1 |
| size_half | input | 1 | 0 selects a byte, 1 selects a halfword |
| signed_en | input | 1 | Requests sign extension; honoured only when `use_imm`=1 |
| use_imm | input | 1 | 0 takes the offset from `sel_reg`, 1 takes it from `sel_imm` |
| result | output | WORD_W (32) | Selected lane, extended to the full width |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, which has four byte lanes and two halfword lanes, and a 4-bit immediate field. Each test word is swept through all eight combinations of size, signedness and offset source, and through all sixteen values of the low four selector bits. This covers every lane and every extension rule. Because the offset has only two significant bits, the sweep also shows directly that the higher bits of both `sel_reg` and `sel_imm` are ignored, that the unused offset source is ignored, and that `signed_en` is ignored in register mode. The test words include all-ones, all-zeros, and lanes whose top bit is set or clear, so that sign extension is exercised in both directions.

// File: rtl/byte_half_select_pkg.sv
// Shared definitions for the lane select unit.
// Assumes lanes are numbered little-endian from bit 0 upward.
package byte_half_select_pkg;

    // Width of one narrow lane kind, selected by the size input.
    typedef enum logic {
        LANE_BYTE = 1'b0,
        LANE_HALF = 1'b1
    } lane_size_e;

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned HALF_BITS = 16;

endpackage

// File: rtl/sel_offset_mux.sv
// Chooses the byte offset from either the register operand or the
// immediate field. Assumes IMM_W and SEL_W are both at least OFS_W;
// only the low OFS_W bits of each source are meaningful.
module sel_offset_mux #(
    parameter int unsigned SEL_W = 32,
    parameter int unsigned IMM_W = 4,
    parameter int unsigned OFS_W = 2
) (
    input  logic [OFS_W-1:0] reg_ofs,
    input  logic [OFS_W-1:0] imm_ofs,
    input  logic             use_imm,
    output logic [OFS_W-1:0] ofs
);

    // Pick the offset source.
    always_comb begin
        ofs = use_imm ? imm_ofs : reg_ofs;
    end

endmodule

// File: rtl/sel_lane_extract.sv
// Splits the source word into byte and halfword lanes and returns the
// lane named by the offset, right-aligned, plus that lane's top bit.
// Assumes WORD_W is a multiple of 16 and at least 32. Halfword lanes
// use only the offset bits above bit 0.
module sel_lane_extract
    import byte_half_select_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned OFS_W  = 2
) (
    input  logic [WORD_W-1:0]    src_word,
    input  logic [OFS_W-1:0]     ofs,
    input  lane_size_e           lane_size,
    output logic [HALF_BITS-1:0] narrow,
    output logic                 lane_msb
);

    localparam int unsigned BYTES  = WORD_W / BYTE_BITS;
    localparam int unsigned HALVES = WORD_W / HALF_BITS;

    logic [BYTE_BITS-1:0] byte_lane [BYTES];
    logic [HALF_BITS-1:0] half_lane [HALVES];
    logic [BYTE_BITS-1:0] byte_pick;
    logic [HALF_BITS-1:0] half_pick;

    for (genvar gb = 0; gb < BYTES; gb++) begin : g_bytes
        assign byte_lane[gb] = src_word[gb*BYTE_BITS +: BYTE_BITS];
    end

    for (genvar gh = 0; gh < HALVES; gh++) begin : g_halves
        assign half_lane[gh] = src_word[gh*HALF_BITS +: HALF_BITS];
    end

    // Index each lane array by its share of the offset.
    always_comb begin
        byte_pick = byte_lane[ofs];
        half_pick = half_lane[ofs[OFS_W-1:1]];
    end

    // Present the chosen lane and its top bit.
    always_comb begin
        if (lane_size == LANE_HALF) begin
            narrow   = half_pick;
            lane_msb = half_pick[HALF_BITS-1];
        end else begin
            narrow   = {{(HALF_BITS-BYTE_BITS){1'b0}}, byte_pick};
            lane_msb = byte_pick[BYTE_BITS-1];
        end
    end

endmodule

// File: rtl/sel_extend.sv
// Widens a right-aligned lane to a full word, filling the upper bits
// with zeros or with the lane's top bit. Assumes narrow holds a byte in
// its low 8 bits when lane_size is byte.
module sel_extend
    import byte_half_select_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic [HALF_BITS-1:0] narrow,
    input  logic                 lane_msb,
    input  lane_size_e           lane_size,
    input  logic                 sign_req,
    output logic [WORD_W-1:0]    wide
);

    logic fill;

    // Fill bit is the lane's top bit only when sign extension is asked for.
    always_comb begin
        fill = sign_req & lane_msb;
    end

    // Build the full-width word for the selected lane size.
    always_comb begin
        if (lane_size == LANE_HALF) begin
            wide = {{(WORD_W-HALF_BITS){fill}}, narrow};
        end else begin
            wide = {{(WORD_W-BYTE_BITS){fill}}, narrow[BYTE_BITS-1:0]};
        end
    end

endmodule

// File: rtl/byte_half_select.sv
// Lane select unit: picks a byte or halfword from src_word at a byte
// offset taken from sel_reg or sel_imm and widens it to WORD_W bits.
// Register-indexed selection always zero-extends; immediate-indexed
// selection sign-extends when signed_en is set. One register stage with
// synchronous active-low reset holds the result.
module byte_half_select
    import byte_half_select_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IMM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] src_word,
    input  logic [WORD_W-1:0] sel_reg,
    input  logic [IMM_W-1:0]  sel_imm,
    input  logic              size_half,
    input  logic              signed_en,
    input  logic              use_imm,
    output logic [WORD_W-1:0] result
);

    localparam int unsigned OFS_W = $clog2(WORD_W / BYTE_BITS);

    logic [OFS_W-1:0]     ofs;
    logic [HALF_BITS-1:0] narrow;
    logic                 lane_msb;
    logic [WORD_W-1:0]    wide;
    lane_size_e           lane_size;
    logic                 sign_req;
    logic                 unused_sel_hi;

    // Offset bits above the lane index carry no meaning here.
    assign unused_sel_hi = ^{sel_reg[WORD_W-1:OFS_W], sel_imm[IMM_W-1:OFS_W]};

    // Decode the size and the effective signedness.
    always_comb begin
        lane_size = size_half ? LANE_HALF : LANE_BYTE;
        sign_req  = signed_en & use_imm;
    end

    sel_offset_mux #(
        .SEL_W (WORD_W),
        .IMM_W (IMM_W),
        .OFS_W (OFS_W)
    ) ofs_mux_i (
        .reg_ofs (sel_reg[OFS_W-1:0]),
        .imm_ofs (sel_imm[OFS_W-1:0]),
        .use_imm (use_imm),
        .ofs     (ofs)
    );

    sel_lane_extract #(
        .WORD_W (WORD_W),
        .OFS_W  (OFS_W)
    ) extract_i (
        .src_word  (src_word),
        .ofs       (ofs),
        .lane_size (lane_size),
        .narrow    (narrow),
        .lane_msb  (lane_msb)
    );

    sel_extend #(
        .WORD_W (WORD_W)
    ) extend_i (
        .narrow    (narrow),
        .lane_msb  (lane_msb),
        .lane_size (lane_size),
        .sign_req  (sign_req),
        .wide      (wide)
    );

    // Register the widened lane; clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else begin
            result <= wide;
        end
    end

endmodule

// File: rtl/byte_half_select_chk.sv
// Checker for the lane select unit, bound to every instance of it.
// Assumes the one-cycle latency of the result register.
module byte_half_select_chk #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IMM_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] src_word,
    input logic [WORD_W-1:0] sel_reg,
    input logic [IMM_W-1:0]  sel_imm,
    input logic              size_half,
    input logic              signed_en,
    input logic              use_imm,
    input logic [WORD_W-1:0] result
);

    localparam int unsigned OFS_W = $clog2(WORD_W / 8);

    logic [WORD_W-1:0] reg_byte_shift;
    logic [WORD_W-1:0] imm_half_shift;
    logic              unused_chk_hi;

    assign unused_chk_hi  = ^{sel_reg[WORD_W-1:OFS_W], sel_imm[IMM_W-1:OFS_W]};
    assign reg_byte_shift = src_word >> {sel_reg[OFS_W-1:0], 3'b000};
    assign imm_half_shift = src_word >> {sel_imm[OFS_W-1:1], 4'b0000};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> result == '0); // R1

    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && !size_half) |=> result[7:0] == $past(reg_byte_shift[7:0])); // R3

    AST_HALF_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && size_half) |=> result[15:0] == $past(imm_half_shift[15:0])); // R4

    AST_REG_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        !use_imm |=> (size_half ? result[WORD_W-1:16] == '0
                                : result[WORD_W-1:8] == '0)); // R7

    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && signed_en && !size_half) |=>
            (result[WORD_W-1:7] == '0 || result[WORD_W-1:7] == '1)); // R8

endmodule

bind byte_half_select byte_half_select_chk #(
    .WORD_W (WORD_W),
    .IMM_W  (IMM_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_word  (src_word),
    .sel_reg   (sel_reg),
    .sel_imm   (sel_imm),
    .size_half (size_half),
    .signed_en (signed_en),
    .use_imm   (use_imm),
    .result    (result)
);

// File: tb/byte_half_select_tb_top.sv
// Sweeps the lane select unit over words, modes and selector values,
// comparing against an arithmetic model of the requirements.
module byte_half_select_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_word = '0;
    logic [31:0] sel_reg = '0;
    logic [3:0]  sel_imm = '0;
    logic        size_half = 1'b0;
    logic        signed_en = 1'b0;
    logic        use_imm = 1'b0;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    byte_half_select dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_word  (src_word),
        .sel_reg   (sel_reg),
        .sel_imm   (sel_imm),
        .size_half (size_half),
        .signed_en (signed_en),
        .use_imm   (use_imm),
        .result    (result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Arithmetic model: shift the lane down, mask it, add the sign fill.
    function automatic logic [31:0] model(input logic [31:0] w, input logic [1:0] ofs,
                                          input logic half, input logic sgn);
        logic [31:0] v;
        if (half) begin
            v = (w >> (32'(ofs[1]) * 16)) & 32'h0000_FFFF;
            if (sgn && v >= 32'h0000_8000) v = v - 32'h0001_0000;
        end else begin
            v = (w >> (32'(ofs) * 8)) & 32'h0000_00FF;
            if (sgn && v >= 32'h0000_0080) v = v - 32'h0000_0100;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s: result=%h expected=%h (src=%h reg=%h imm=%h half=%0b sgn=%0b imm_sel=%0b)",
                     req, result, exp, src_word, sel_reg, sel_imm, size_half, signed_en, use_imm);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [31:0] r, input logic [3:0] i,
                         input logic half, input logic sgn, input logic ui);
        @(negedge clk);
        src_word  = w;
        sel_reg   = r;
        sel_imm   = i;
        size_half = half;
        signed_en = sgn;
        use_imm   = ui;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    initial begin
        logic [31:0] words [6];
        logic [31:0] first_exp;
        words[0] = 32'h8765_4321;
        words[1] = 32'h80FF_7F01;
        words[2] = 32'hFFFF_FFFF;
        words[3] = 32'h0000_0000;
        words[4] = 32'h7F80_8000;
        words[5] = 32'hA5C3_3C5A;

        // R1: result stays clear under reset even with live inputs.
        apply(32'hDEAD_BEEF, 32'h3, 4'h1, 1'b0, 1'b1, 1'b1);
        check("R1", 32'h0);
        apply(32'hFFFF_FFFF, 32'h2, 4'h2, 1'b1, 1'b1, 1'b1);
        check("R1", 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: the result holds between edges and follows the sampled inputs.
        apply(32'h1122_3344, 32'h1, 4'h0, 1'b0, 1'b0, 1'b0);
        first_exp = 32'h0000_0033;
        check("R2", first_exp);
        @(negedge clk);
        src_word = 32'hFFEE_DDCC;
        sel_reg  = 32'h3;
        #(CLK_PERIOD/4);
        check("R2", first_exp);
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R2", 32'h0000_00FF);

        // Sweep every word, every mode and every low selector pattern.
        for (int p = 0; p < 6; p++) begin
            for (int m = 0; m < 8; m++) begin
                for (int s = 0; s < 16; s++) begin
                    logic ui, half, sgn;
                    logic [31:0] r;
                    logic [3:0] i;
                    logic [1:0] ofs;
                    string tag;
                    ui   = m[0];
                    half = m[1];
                    sgn  = m[2];
                    r    = ((32'h9E37_79B9 * 32'(s + 1 + p)) & 32'hFFFF_FFF0);
                    if (ui) begin
                        // R6: the register operand disagrees with the immediate.
                        i   = 4'(s);
                        r   = r | 32'(~s & 4'hF);
                        ofs = i[1:0];
                    end else begin
                        // R5: the immediate disagrees with the register operand.
                        r   = r | 32'(s & 4'hF);
                        i   = 4'(~s);
                        ofs = r[1:0];
                    end
                    tag = half ? "R4" : "R3";
                    if (ui) tag = {tag, sgn ? " R6 R8" : " R6"};
                    else    tag = {tag, " R5 R7"};
                    apply(words[p], r, i, half, sgn, ui);
                    check(tag, model(words[p], ofs, half, sgn & ui));
                end
            end
        end

        // R1: asserting reset again clears a non-zero result.
        apply(32'hFFFF_FFFF, 32'h0, 4'h0, 1'b1, 1'b1, 1'b1);
        check("R8", 32'hFFFF_FFFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R1", 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: result=%h expected=completion", result);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule